// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor and a block-wide memory. It holds a direct-mapped set of lines. Each line has a tag, a valid flag and a modified flag. It follows a write-allocate, write-back policy. Loads and stores that hit are served from the line store in the same cycle. A store that hits changes one byte of the line and marks the line modified. Memory is not touched on any hit.

When an access misses, the processor is stalled. If the victim line is both valid and modified, the controller first copies it out to memory. The write-back goes to the block address made of the stored tag joined with the line index. The controller then fetches the requested block and installs the new tag. The line becomes valid and unmodified. Last, the controller replays the original access against the fresh line.

The controller has four states:
- **IDLE** serves hits and detects misses.
- **WRITEBACK** copies out a modified victim.
- **FILL** fetches the new block.
- **RETRY** replays the access.

It has four transitions:
- **miss-dirty** (IDLE→WRITEBACK)
- **miss-clean** (IDLE→FILL)
- **victim-saved** (WRITEBACK→FILL, on memory acknowledge)
- **block-loaded** (FILL→RETRY, on memory acknowledge)

RETRY always returns to IDLE through the **replay-done** transition.

Addresses are byte addresses. Field positions with default parameters:
- bits [3:0] are the byte offset
- bits [7:4] are the line index
- bits [15:8] are the tag

Memory addresses are block addresses, that is, bits [15:4].

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid, and `cpu_stall`, `cpu_ack` and `mem_req` are low.
- R2: A load that hits raises `cpu_ack` in the same cycle with `cpu_stall` low. `cpu_rdata` is the 32-bit word chosen by address bits [3:2], little-endian, so the byte at the lowest address sits in bits [7:0]. No memory transfer takes place.
- R3: A store that hits raises `cpu_ack` in the same cycle. It writes `cpu_wbyte` to the byte at offset bits [3:0] of the indexed line and marks the line modified. No memory transfer takes place.
- R4: On a miss, `cpu_stall` is high in every cycle from the miss cycle up to the replay cycle. In the replay cycle `cpu_ack` is high and `cpu_stall` is low.
- R5: When the victim is valid and modified, one block write to address {stored tag, index} completes before the fetch. It carries the full line contents, including every byte stored into it.
- R6: When the victim is invalid or unmodified, no block write is made, and the fetch request starts in the cycle after the miss.
- R7: The fetch reads block {request tag, index}. Afterwards the line holds the new tag, valid set and modified cleared. Later accesses to that block hit, and evicting it without an intervening store writes nothing back.
- R8: The replayed access completes on the fetched line. A load returns the word from the new block. A store merges its byte into the fetched block and marks the line modified.
- R9: `mem_req` stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_ack` is high. Each acknowledged request moves exactly one block.
- R10: A miss costs one block read, plus one block write only when the victim is valid and modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 = store one byte, 0 = load one word |
| cpu_addr | input | 16 | Byte address |
| cpu_wbyte | input | 8 | Byte to store |
| cpu_rdata | output | 32 | Load result, valid while `cpu_ack` is high |
| cpu_ack | output | 1 | Access completes this cycle |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_req | output | 1 | Block transfer request |
| mem_we | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_addr | output | 12 | Block address |
| mem_wdata | output | 128 | Block being written back |
| mem_rdata | input | 128 | Fetched block, taken in the `mem_ack` cycle |
| mem_ack | input | 1 | Memory completes the request this cycle |

## Verification
A hit acknowledges in the same cycle it is presented. The bench therefore drives each request just after a falling edge and samples one nanosecond later.

With a memory that acknowledges L cycles after it sees a request:
- An unmodified-victim miss acknowledges L+1 cycles after the request.
- A modified-victim miss acknowledges 2L+2 cycles after the request, because the memory model spends one idle cycle between its two transfers.

The bench counts the sampled cycles up to `cpu_ack` and compares the count with these exact figures. It checks the transfer counts, the write-back address and the written block only after the acknowledge, once every transfer must have finished.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    localparam int ADDR_W_DEF     = 16;
    localparam int LINE_BYTES_DEF = 16;
    localparam int WORD_BYTES_DEF = 4;
    localparam int LINES_DEF      = 16;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WRITEBACK = 2'd1,
        ST_FILL      = 2'd2,
        ST_RETRY     = 2'd3
    } wbc_state_e;

endpackage

// File: rtl/wbc_tags.sv
module wbc_tags #(
    parameter int LINES = 16,
    parameter int TAG_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] tag_in,
    input  logic             set_dirty,
    input  logic             install,
    output logic             hit,
    output logic             vic_valid,
    output logic             vic_dirty,
    output logic [TAG_W-1:0] vic_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (set_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[idx] <= tag_in;
        end
    end

    always_comb begin
        vic_valid = valid_q[idx];
        vic_dirty = dirty_q[idx];
        vic_tag   = tag_q[idx];
        hit       = vic_valid && (vic_tag == tag_in);
    end

    logic [IDX_W-1:0] chk_idx;
    always_ff @(posedge clk) chk_idx <= idx;

    // R3
    dirty_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_dirty |=> dirty_q[chk_idx]);

    // R7
    fill_clears_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        install |=> (valid_q[chk_idx] && !dirty_q[chk_idx]));

endmodule

// File: rtl/wbc_lines.sv
module wbc_lines #(
    parameter int LINES      = 16,
    parameter int LINE_BYTES = 16,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int LINE_W = 8 * LINE_BYTES
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic              byte_we,
    input  logic [OFF_W-1:0]  byte_off,
    input  logic [7:0]        byte_val,
    input  logic              fill_we,
    input  logic [LINE_W-1:0] fill_line,
    output logic [LINE_W-1:0] rd_line
);

    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_lane
        logic [7:0] lane_q [LINES];

        always_ff @(posedge clk) begin
            if (fill_we) begin
                lane_q[idx] <= fill_line[b*8 +: 8];
            end else if (byte_we && (byte_off == OFF_W'(b))) begin
                lane_q[idx] <= byte_val;
            end
        end

        assign rd_line[b*8 +: 8] = lane_q[idx];
    end

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       we,
    input  logic       hit,
    input  logic       vic_valid,
    input  logic       vic_dirty,
    input  logic       mem_ack,
    output wbc_state_e state,
    output logic       use_live,
    output logic       capture,
    output logic       cpu_ack,
    output logic       cpu_stall,
    output logic       mem_req,
    output logic       mem_we,
    output logic       byte_we,
    output logic       set_dirty,
    output logic       fill_we
);

    wbc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        use_live  = 1'b0;
        capture   = 1'b0;
        cpu_ack   = 1'b0;
        cpu_stall = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        byte_we   = 1'b0;
        set_dirty = 1'b0;
        fill_we   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                use_live = 1'b1;
                if (req) begin
                    if (hit) begin
                        cpu_ack   = 1'b1;
                        byte_we   = we;
                        set_dirty = we;
                    end else begin
                        cpu_stall = 1'b1;
                        capture   = 1'b1;
                        state_d   = (vic_valid && vic_dirty) ? ST_WRITEBACK : ST_FILL;
                    end
                end
            end
            ST_WRITEBACK: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                if (mem_ack) state_d = ST_FILL;
            end
            ST_FILL: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                if (mem_ack) begin
                    fill_we = 1'b1;
                    state_d = ST_RETRY;
                end
            end
            ST_RETRY: begin
                cpu_ack   = 1'b1;
                byte_we   = we;
                set_dirty = we;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;

    // R6
    clean_skip_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILL && $past(state_q) == ST_IDLE)
            |-> !($past(vic_valid) && $past(vic_dirty)));

    // R4
    miss_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req && !hit) |=> (cpu_stall && !cpu_ack));

    // R8
    retry_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETRY) |-> (cpu_ack && !cpu_stall && !mem_req));

endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int LINE_BYTES = LINE_BYTES_DEF,
    parameter int WORD_BYTES = WORD_BYTES_DEF,
    parameter int LINES      = LINES_DEF
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     cpu_req,
    input  logic                                     cpu_we,
    input  logic [ADDR_W-1:0]                        cpu_addr,
    input  logic [7:0]                               cpu_wbyte,
    output logic [8*WORD_BYTES-1:0]                  cpu_rdata,
    output logic                                     cpu_ack,
    output logic                                     cpu_stall,
    output logic                                     mem_req,
    output logic                                     mem_we,
    output logic [ADDR_W-$clog2(LINE_BYTES)-1:0]     mem_addr,
    output logic [8*LINE_BYTES-1:0]                  mem_wdata,
    input  logic [8*LINE_BYTES-1:0]                  mem_rdata,
    input  logic                                     mem_ack
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(LINES);
    localparam int TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int WB_W   = $clog2(WORD_BYTES);
    localparam int WSEL_W = OFF_W - WB_W;
    localparam int WORDS  = LINE_BYTES / WORD_BYTES;
    localparam int WORD_W = 8 * WORD_BYTES;
    localparam int LINE_W = 8 * LINE_BYTES;

    wbc_state_e state;
    logic use_live, capture, byte_we, set_dirty, fill_we;
    logic hit, vic_valid, vic_dirty;
    logic [TAG_W-1:0] vic_tag;

    logic              q_we;
    logic [ADDR_W-1:0] q_addr;
    logic [7:0]        q_byte;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_we   <= 1'b0;
            q_addr <= '0;
            q_byte <= '0;
        end else if (capture) begin
            q_we   <= cpu_we;
            q_addr <= cpu_addr;
            q_byte <= cpu_wbyte;
        end
    end

    logic              acc_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [7:0]        acc_byte;
    logic [TAG_W-1:0]  acc_tag;
    logic [IDX_W-1:0]  acc_idx;
    logic [OFF_W-1:0]  acc_off;
    logic [WSEL_W-1:0] wsel;

    always_comb begin
        acc_we   = use_live ? cpu_we    : q_we;
        acc_addr = use_live ? cpu_addr  : q_addr;
        acc_byte = use_live ? cpu_wbyte : q_byte;
        acc_tag  = acc_addr[ADDR_W-1 -: TAG_W];
        acc_idx  = acc_addr[OFF_W +: IDX_W];
        acc_off  = acc_addr[OFF_W-1:0];
        wsel     = acc_off[OFF_W-1:WB_W];
    end

    wbc_tags #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (acc_idx),
        .tag_in    (acc_tag),
        .set_dirty (set_dirty),
        .install   (fill_we),
        .hit       (hit),
        .vic_valid (vic_valid),
        .vic_dirty (vic_dirty),
        .vic_tag   (vic_tag)
    );

    logic [LINE_W-1:0] line_rd;

    wbc_lines #(.LINES(LINES), .LINE_BYTES(LINE_BYTES)) u_lines (
        .clk       (clk),
        .idx       (acc_idx),
        .byte_we   (byte_we),
        .byte_off  (acc_off),
        .byte_val  (acc_byte),
        .fill_we   (fill_we),
        .fill_line (mem_rdata),
        .rd_line   (line_rd)
    );

    wbc_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (cpu_req),
        .we        (acc_we),
        .hit       (hit),
        .vic_valid (vic_valid),
        .vic_dirty (vic_dirty),
        .mem_ack   (mem_ack),
        .state     (state),
        .use_live  (use_live),
        .capture   (capture),
        .cpu_ack   (cpu_ack),
        .cpu_stall (cpu_stall),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .byte_we   (byte_we),
        .set_dirty (set_dirty),
        .fill_we   (fill_we)
    );

    logic [WORD_W-1:0] words [WORDS];
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign words[w] = line_rd[w*WORD_W +: WORD_W];
    end

    assign cpu_rdata = words[wsel];
    assign mem_wdata = line_rd;
    assign mem_addr  = mem_we ? {vic_tag, acc_idx} : {acc_tag, acc_idx};

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    // R5
    wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (vic_valid && vic_dirty));

    // R7
    retry_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RETRY) |-> hit);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !cpu_stall));

endmodule

// File: tb/wbc_cache_bench.sv
`timescale 1ns/1ps
module wbc_cache_bench;

    localparam int LAT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cpu_req = 1'b0;
    logic         cpu_we = 1'b0;
    logic [15:0]  cpu_addr = '0;
    logic [7:0]   cpu_wbyte = '0;
    logic [31:0]  cpu_rdata;
    logic         cpu_ack, cpu_stall;
    logic         mem_req, mem_we;
    logic [11:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic [127:0] mem_rdata = '0;
    logic         mem_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int n_rd = 0;
    int n_wr = 0;
    int mcnt = 0;
    logic [11:0] last_wr_addr = '0;
    logic [11:0] first_addr = '0;

    logic [127:0] mem [int unsigned];
    logic [7:0]   truth [int unsigned];

    always #2 clk = ~clk;

    wbc_cache u_wbc_cache (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wbyte(cpu_wbyte),
        .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    function automatic logic [7:0] init_byte(int unsigned a);
        return 8'((a >> 4) * 13 + (a & 15) * 5 + 1);
    endfunction

    function automatic logic [7:0] tbyte(int unsigned a);
        return truth.exists(a) ? truth[a] : init_byte(a);
    endfunction

    function automatic logic [127:0] truth_block(int unsigned blk);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = tbyte(blk * 16 + i);
        return v;
    endfunction

    function automatic logic [127:0] mem_block(int unsigned blk);
        logic [127:0] v;
        if (mem.exists(blk)) return mem[blk];
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = init_byte(blk * 16 + i);
        return v;
    endfunction

    function automatic logic [31:0] exp_word(int unsigned a);
        int unsigned b = a & ~32'd3;
        return {tbyte(b + 3), tbyte(b + 2), tbyte(b + 1), tbyte(b)};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // memory model: acknowledges LAT cycles after it sees a request, one idle cycle after each ack
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (rst_n && mem_req) begin
            mcnt++;
            if (mcnt == 1) first_addr = mem_addr;
            if (mcnt == LAT) begin
                mcnt = 0;
                chk(first_addr == mem_addr, "R9 address held", 128'(mem_addr), 128'(first_addr));
                mem_ack = 1'b1;
                if (mem_we) begin
                    mem[mem_addr] = mem_wdata;
                    last_wr_addr  = mem_addr;
                    n_wr++;
                end else begin
                    mem_rdata = mem_block(mem_addr);
                    n_rd++;
                end
            end
        end
    end

    task automatic access(input bit we, input logic [15:0] a, input logic [7:0] b,
                          input int exp_lat, input int exp_rd, input int exp_wr,
                          input string req);
        int r0 = n_rd;
        int w0 = n_wr;
        int lat = 0;
        int stalls = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wbyte = b;
        #1;
        while (!cpu_ack && lat < 200) begin
            if (cpu_stall) stalls++;
            @(negedge clk); #1;
            lat++;
        end
        chk(lat == exp_lat, {req, " latency"}, 128'(lat), 128'(exp_lat));
        chk(stalls == exp_lat && !cpu_stall, "R4 stall cycles", 128'(stalls), 128'(exp_lat));
        if (!we) chk(cpu_rdata == exp_word(a), {req, " data"}, 128'(cpu_rdata), 128'(exp_word(a)));
        else truth[a] = b;
        chk(n_rd - r0 == exp_rd, "R10 block reads", 128'(n_rd - r0), 128'(exp_rd));
        chk(n_wr - w0 == exp_wr, "R10 block writes", 128'(n_wr - w0), 128'(exp_wr));
        @(negedge clk);
        cpu_req = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        chk(!cpu_stall && !cpu_ack && !mem_req, "R1 outputs quiet",
            128'({cpu_stall, cpu_ack, mem_req}), 128'(0));
    endtask

    task automatic t_read_miss_cold;
        // R6 invalid victim, R7 fill, R8 replayed load
        access(1'b0, 16'h1234, 8'h00, LAT + 1, 1, 0, "R8 cold load miss");
    endtask

    task automatic t_read_hit;
        access(1'b0, 16'h1238, 8'h00, 0, 0, 0, "R2 load hit word2");
        access(1'b0, 16'h123C, 8'h00, 0, 0, 0, "R2 load hit word3");
    endtask

    task automatic t_write_hit;
        access(1'b1, 16'h1239, 8'hA5, 0, 0, 0, "R3 store hit");
        access(1'b0, 16'h1238, 8'h00, 0, 0, 0, "R3 store visible");
    endtask

    task automatic t_dirty_evict;
        logic [127:0] exp_blk = truth_block(12'h123);
        access(1'b0, 16'h5634, 8'h00, 2 * LAT + 2, 1, 1, "R5 modified victim");
        chk(last_wr_addr == 12'h123, "R5 write-back address", 128'(last_wr_addr), 128'(12'h123));
        chk(mem_block(12'h123) == exp_blk, "R5 write-back contents", mem_block(12'h123), exp_blk);
    endtask

    task automatic t_clean_evict;
        // R7: line filled by a load is unmodified, eviction writes nothing
        access(1'b0, 16'h1238, 8'h00, LAT + 1, 1, 0, "R6 unmodified victim");
        access(1'b0, 16'h1230, 8'h00, 0, 0, 0, "R7 refilled line hits");
    endtask

    task automatic t_write_miss_cold;
        access(1'b1, 16'h20F1, 8'h3C, LAT + 1, 1, 0, "R8 store miss");
        access(1'b0, 16'h20F0, 8'h00, 0, 0, 0, "R8 merged byte");
    endtask

    task automatic t_write_miss_dirty;
        logic [127:0] exp_blk = truth_block(12'h20F);
        access(1'b1, 16'h77F2, 8'h81, 2 * LAT + 2, 1, 1, "R10 store miss modified");
        chk(last_wr_addr == 12'h20F, "R5 write-back address", 128'(last_wr_addr), 128'(12'h20F));
        chk(mem_block(12'h20F) == exp_blk, "R5 write-back contents", mem_block(12'h20F), exp_blk);
        access(1'b0, 16'h77F0, 8'h00, 0, 0, 0, "R8 store miss merged");
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_miss_cold();
        t_read_hit();
        t_write_hit();
        t_dirty_evict();
        t_clean_evict();
        t_write_miss_cold();
        t_write_miss_dirty();
        repeat (3) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule